// File: doc/BRIEF.md
# Serial Sampling Converter Device-Side Port

This block is a synthesizable digital model of the device end of a three-wire serial sampling converter. A host drives an active-low select and a serial clock. A parallel word stands in for the analog value being sampled. The block frames each conversion and shifts the previous conversion's result out on a serial data line. That line is modelled as a data bit plus an output enable. The block also decodes the power-down and wake-up commands that the host signals with the same two wires.

All inputs are treated as synchronous to the system clock `clk`. Edges on select and serial clock are found by comparing each sample with the one taken a cycle earlier. Wake-up delays are counted in `clk` cycles. Analog behaviour and the real conversion timing are not modelled.

Top module: `serial_adc_port`

## Requirements
- R1: While `cs_n` is high, `sdo_oe` is 0 and `sdo` is 0. The first `clk` edge that sees `cs_n` low after it was high starts a frame. `sdo_oe` is then 1 and the first bit driven is 0.
- R2: If `sck` was low in the cycle before the frame started, one leading 0 is sent before the data. If `sck` was high, two leading 0s are sent.
- R3: After the leading zeros, each `sck` falling edge presents the next bit of a `DW`-bit straight-binary word, MSB first. Falling edges after the LSB present 0.
- R4: `sdo_oe` drops to 0 after the 16th `sck` falling edge of a frame, and it stays 0 until the next frame.
- R5: The word sent in a frame is the `sample_in` value captured at the start of the most recent frame that completed. A result is held only once 14 falling edges have been seen. After reset, the held result is 0.
- R6: A frame in which `cs_n` rises before the 14th `sck` falling edge is aborted. It leaves the held result unchanged.
- R7: Two complete `cs_n` low pulses with no `sck` edge put the port into nap (`pwr_state` = 1). Four such pulses put it into sleep (`pwr_state` = 2). Active is `pwr_state` = 0. In nap or sleep, no frame starts and `sdo_oe` stays 0.
- R8: Any `sck` edge clears the pulse count. A frame that contains `sck` edges does not count as a pulse.
- R9: An `sck` rising edge in nap or sleep returns `pwr_state` to 0. After nap, the next frame converts and reads out normally.
- R10: After a wake from sleep, `not_ready` is 1 for `WAKE_CYC` cycles. A frame started while `not_ready` is 1 sends only zeros and does not update the held result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select; frames a conversion |
| sck | input | 1 | Serial clock from the host |
| sample_in | input | DW | Word standing in for the analog input |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Output enable; 0 means high impedance |
| pwr_state | output | 2 | 0 active, 1 nap, 2 sleep |
| not_ready | output | 1 | Reference recovery wait after sleep |

## Verification
The bench sweeps many data words in both leading-zero modes and follows each frame past the 16th falling edge.
- A port that took the idle `sck` level at the wrong moment would shift the whole word by one bit.
- A port without the one-frame latency would echo the current `sample_in` instead of the previous value.
- Aborted frames and frames started during the recovery wait are checked against the last committed result. A design that committed on the wrong edge or ignored the wait would show the new word.
- The pulse-count corner, where pulses are split by an `sck` pulse, catches a counter that is never cleared. Such a counter would drop the port into nap while a normal host is using it.

// File: rtl/serial_adc_port.sv
module serial_adc_port #(
  parameter int DW       = 12,
  parameter int WAKE_CYC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic [DW-1:0] sample_in,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [1:0]    pwr_state,
  output logic          not_ready
);
  localparam int FRAME  = DW + 4;
  localparam int COMMIT = DW + 2;
  localparam int CW     = $clog2(FRAME + 1);
  localparam int WW     = $clog2(WAKE_CYC + 1);
  localparam logic [1:0] ACT = 2'd0, NAP = 2'd1, SLP = 2'd2;

  logic          cs_q, sck_q, frame, lead2, dead, sck_seen;
  logic [CW-1:0] cnt;
  logic [DW-1:0] word, samp, result;
  logic [2:0]    pcnt;
  logic [1:0]    pstate;
  logic [WW-1:0] wake_cnt;

  wire cs_fall  = cs_q & ~cs_n;
  wire cs_rise  = ~cs_q & cs_n;
  wire sck_fall = sck_q & ~sck;
  wire sck_rise = ~sck_q & sck;
  wire sck_edge = sck_fall | sck_rise;
  wire recovering = (wake_cnt != '0);
  wire [2:0] pnext = (pcnt == 3'd4) ? 3'd4 : pcnt + 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b1; sck_q <= 1'b0; frame <= 1'b0; lead2 <= 1'b0;
      dead <= 1'b0; sck_seen <= 1'b0; cnt <= '0; word <= '0;
      samp <= '0; result <= '0; pcnt <= '0; pstate <= ACT; wake_cnt <= '0;
    end else begin
      cs_q  <= cs_n;
      sck_q <= sck;
      if (recovering) wake_cnt <= wake_cnt - 1'b1;
      if (sck_edge) begin
        pcnt     <= '0;
        sck_seen <= 1'b1;
      end
      if (cs_fall) begin
        sck_seen <= 1'b0;
        if (pstate == ACT) begin
          frame <= 1'b1;
          cnt   <= '0;
          lead2 <= sck_q;
          samp  <= sample_in;
          dead  <= recovering;
          word  <= recovering ? '0 : result;
        end
      end
      if (cs_rise) begin
        frame <= 1'b0;
        if (!sck_seen && !sck_edge) begin
          pcnt <= pnext;
          if (pnext == 3'd2 && pstate == ACT) pstate <= NAP;
          if (pnext == 3'd4) pstate <= SLP;
        end
      end
      if (frame && sck_fall && !cs_rise && cnt != CW'(FRAME)) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(COMMIT - 1) && !dead) result <= samp;
      end
      if (sck_rise && pstate != ACT) begin
        pstate <= ACT;
        if (pstate == SLP) wake_cnt <= WW'(WAKE_CYC);
      end
    end
  end

  logic bitv;
  always_comb begin
    int k;
    k    = int'(cnt) - (lead2 ? 2 : 1);
    bitv = 1'b0;
    if (k >= 0 && k < DW) bitv = word[DW-1-k];
  end

  assign sdo_oe    = frame && (cnt != CW'(FRAME));
  assign sdo       = sdo_oe & bitv;
  assign pwr_state = pstate;
  assign not_ready = recovering;
endmodule

// File: rtl/serial_adc_port_chk.sv
module serial_adc_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sdo,
  input logic       sdo_oe,
  input logic [1:0] pwr_state,
  input logic       not_ready
);
  a_r1_hiz_while_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo_oe);
  a_r1_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
  a_r7_no_output_powered_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'd0) |-> !sdo_oe);
  a_r7_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'd3);
  a_r10_wait_follows_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(not_ready) |-> $past(pwr_state) == 2'd2);
endmodule

bind serial_adc_port serial_adc_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe),
  .pwr_state(pwr_state), .not_ready(not_ready));

// File: tb/test_serial_adc_port.sv
module test_serial_adc_port;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0;
  logic [11:0] din = '0;
  logic sdo, sdo_oe, not_ready;
  logic [1:0] pwr_state;
  int checks = 0, fails = 0;
  logic [11:0] model_res = '0;
  bit rec = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_adc_port i_serial_adc_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sample_in(din),
    .sdo(sdo), .sdo_oe(sdo_oe), .pwr_state(pwr_state), .not_ready(not_ready));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tg, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic frame(input bit hi, input logic [11:0] w, input int nf, input string tg);
    logic [11:0] shown;
    int L;
    shown = rec ? 12'd0 : model_res;
    L = hi ? 2 : 1;
    sck = hi; din = w; step();
    cs_n = 1'b0; step();
    chk(sdo_oe && !sdo, {tg, " R1 start"}, {sdo_oe, sdo}, 2);
    for (int p = 1; p <= nf; p++) begin
      if (!sck) begin sck = 1'b1; step(); end
      sck = 1'b0; step();
      if (p >= 16) chk(!sdo_oe, {tg, " R4 hiz"}, sdo_oe, 0);
      else begin
        int k;
        logic e;
        k = p - L;
        e = (k >= 0 && k < 12) ? shown[11-k] : 1'b0;
        chk(sdo_oe && sdo == e, (k < 0) ? {tg, " R2 lead"} : {tg, " R3/R5 data"},
            {sdo_oe, sdo}, {1'b1, e});
      end
    end
    cs_n = 1'b1; step();
    chk(!sdo_oe && !sdo, {tg, " R1 deselect"}, sdo_oe, 0);
    if (nf >= 14 && !rec) model_res = w;
  endtask

  task automatic pulse();
    cs_n = 1'b0; step();
    cs_n = 1'b1; step();
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1; step();
    chk(!sdo_oe && pwr_state == 2'd0 && !not_ready, "R1 reset", {sdo_oe, pwr_state, not_ready}, 0);

    frame(1'b0, 12'hABC, 16, "R5 first");
    for (int v = 0; v < 4096; v += 97) begin
      frame(v[0], v[11:0], 16 + (v % 3), "sweep");
      frame(!v[0], ~v[11:0], 16, "sweep");
    end
    frame(1'b1, 12'hFFF, 16, "R3 ones");
    frame(1'b0, 12'h000, 17, "R3 zeros");
    frame(1'b1, 12'h555, 16, "R2 hi");

    frame(1'b0, 12'h3C3, 13, "R6 abort");
    frame(1'b1, 12'h0F0, 14, "R6 after");
    frame(1'b0, 12'h0F0, 16, "R6 check");

    pulse(); sck = 1'b1; step(); sck = 1'b0; step(); pulse();
    chk(pwr_state == 2'd0, "R8 split pulses", pwr_state, 0);
    frame(1'b0, 12'h111, 16, "R8 frame");
    pulse();
    chk(pwr_state == 2'd0, "R8 frame not counted", pwr_state, 0);
    frame(1'b0, 12'h222, 16, "R8 frame2");

    pulse(); pulse();
    chk(pwr_state == 2'd1, "R7 nap", pwr_state, 1);
    cs_n = 1'b0; step();
    chk(!sdo_oe, "R7 nap quiet", sdo_oe, 0);
    cs_n = 1'b1; step();
    sck = 1'b1; step();
    chk(pwr_state == 2'd0 && !not_ready, "R9 wake nap", {pwr_state, not_ready}, 0);
    sck = 1'b0; step();
    frame(1'b0, 12'h9A5, 16, "R9 after nap");

    pulse(); pulse(); pulse(); pulse();
    chk(pwr_state == 2'd2, "R7 sleep", pwr_state, 2);
    sck = 1'b1; step();
    chk(pwr_state == 2'd0 && not_ready, "R10 wake sleep", {pwr_state, not_ready}, 1);
    sck = 1'b0; step();
    rec = 1'b1;
    frame(1'b0, 12'h777, 16, "R10 recovering");
    rec = 1'b0;
    chk(not_ready, "R10 still waiting", not_ready, 1);
    repeat (70) step();
    chk(!not_ready, "R10 wait over", not_ready, 0);
    frame(1'b0, 12'h246, 16, "R10 held");
    frame(1'b1, 12'h000, 16, "R10 new");

    finish_run();
  end
endmodule